// File: doc/BRIEF.md
# Two-Level I/O Page Table Walker

This block turns a 32-bit device address into a physical address. It does this by reading a two-level translation table held in memory. A client offers an address on a valid/ready handshake. The walker then issues one or two word reads on a simple request/response memory port. When the walk ends, it presents a one-cycle result: the physical address and a two-bit page-size code that can be written straight into a TLB entry, or a fault flag together with the offending device address.

The first-level table has 4096 word descriptors, one for each 1 MB of the 4 GB device space. Each of these descriptors does one of three things:
- it maps a 1 MB section directly;
- it maps a 16 MB supersection, which is stored as 16 identical copies;
- it points to a second-level table of 256 words.

Second-level descriptors map 4 KB small pages or 64 KB large pages. Large pages are also stored as 16 identical copies. Because of this replication, the walker always applies the mask of the larger page, whichever copy it happens to read.

The walker accepts a new request only when it is idle. It keeps at most one memory read in flight.

Top module: `iopt_walker`

## Requirements
- R1: While reset is asserted and right after it, `req_ready_o` is 1, and both `mem_req_o` and `res_valid_o` are 0.
- R2: The first read of a walk goes to address {tbl_base_i[17:0], addr[31:20], 2'b00}, where tbl_base_i and addr are the values captured at acceptance. `mem_req_o` is high for exactly one cycle per read, and a new read is never issued while one is outstanding.
- R3: A first-level descriptor with bits 1:0 = 10 and bit 18 = 0 is a section. The result is {desc[31:20], addr[19:0]} with size code 2'b00.
- R4: A first-level descriptor with bits 1:0 = 10 and bit 18 = 1 is a supersection. The result is {desc[31:24], addr[23:0]} with size code 2'b11. Descriptor bits 23:20 have no effect.
- R5: A first-level descriptor with bits 1:0 = 01 is a table pointer. It causes a second read at {desc[31:10], addr[19:12], 2'b00}.
- R6: A second-level descriptor with bits 1:0 = 01 is a large page. The result is {desc[31:16], addr[15:0]} with size code 2'b01. Descriptor bits 15:12 have no effect.
- R7: A second-level descriptor with bit 1 set is a small page. The result is {desc[31:12], addr[11:0]} with size code 2'b10, whatever the value of bit 0.
- R8: An all-zero descriptor at either level produces a result with `res_fault_o` = 1, `res_fault_addr_o` equal to the requested address, and `res_pa_o` = 0. This happens after one read (first level) or two reads (second level). On a successful walk, `res_fault_addr_o` is 0.
- R9: A non-zero first-level descriptor whose bits 1:0 are 00 or 11 faults after a single read.
- R10: `req_ready_o` is 1 only when the walker is idle. A `req_valid_i` that arrives during a walk is ignored: it changes neither the result nor the number of reads.
- R11: `res_valid_o` is high for exactly one cycle per accepted request. In the following cycle, `req_ready_o` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tbl_base_i | input | 18 | First-level table base, physical address bits 31:14 |
| req_valid_i | input | 1 | Translation request valid |
| req_addr_i | input | 32 | Device address to translate |
| req_ready_o | output | 1 | Walker idle, request accepted |
| mem_req_o | output | 1 | One-cycle memory read strobe |
| mem_addr_o | output | 32 | Word-aligned read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read descriptor |
| res_valid_o | output | 1 | Result valid, one cycle |
| res_pa_o | output | 32 | Translated physical address |
| res_size_o | output | 2 | Page size: 00 1 MB, 01 64 KB, 10 4 KB, 11 16 MB |
| res_fault_o | output | 1 | Translation fault |
| res_fault_addr_o | output | 32 | Faulting device address |

## Verification
A corrupted walk state shows at the ports within one or two reads. Typical symptoms are:
- a read address whose index bits do not match the requested address;
- a second read where the walk should have ended;
- a missing read where a table pointer was fetched.

A wrong mask choice in a decoder shows up in the very next result, as copied-through address bits at the wrong boundary or a wrong size code. The test descriptors are built so that the ignored bits in replicated entries differ from the address bits they must not replace. A stuck controller either holds `req_ready_o` low or repeats `res_valid_o`, and both are visible in the cycle after the result.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  localparam int VA_W           = 32;
  localparam int PA_W           = 32;
  localparam int DESC_W         = 32;
  localparam int L1_IDX_LSB     = 20;
  localparam int L1_IDX_W       = VA_W - L1_IDX_LSB;
  localparam int L2_IDX_LSB     = 12;
  localparam int L2_IDX_W       = L1_IDX_LSB - L2_IDX_LSB;
  localparam int BASE_W         = PA_W - L1_IDX_W - 2;
  localparam int L2_PTR_LSB     = L2_IDX_W + 2;
  localparam int SECT_LSB       = L1_IDX_LSB;
  localparam int SUPER_LSB      = 24;
  localparam int LARGE_LSB      = 16;
  localparam int SMALL_LSB      = L2_IDX_LSB;
  localparam int SUPER_FLAG_BIT = 18;

  typedef enum logic [1:0] {
    PG_1M  = 2'b00,
    PG_64K = 2'b01,
    PG_4K  = 2'b10,
    PG_16M = 2'b11
  } pg_size_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    L1K_FAULT, L1K_TABLE, L1K_LEAF
  } l1_kind_e;
endpackage

// File: rtl/iopt_l1_dec.sv
module iopt_l1_dec
  import iopt_pkg::*;
(
  input  logic [DESC_W-1:0]    desc_i,
  input  logic [SUPER_LSB-1:0] va_low_i,
  output l1_kind_e             kind_o,
  output logic [PA_W-1:0]      pa_o,
  output pg_size_e             size_o,
  output logic [PA_W-1:0]      l2_addr_o
);
  always_comb begin
    kind_o    = L1K_FAULT;
    pa_o      = '0;
    size_o    = PG_1M;
    l2_addr_o = {desc_i[DESC_W-1:L2_PTR_LSB], va_low_i[L1_IDX_LSB-1:L2_IDX_LSB], 2'b00};
    if (desc_i != '0) begin
      unique case (desc_i[1:0])
        2'b01: kind_o = L1K_TABLE;
        2'b10: begin
          kind_o = L1K_LEAF;
          // replicated 16 MB entry: wide mask regardless of replica
          if (desc_i[SUPER_FLAG_BIT]) begin
            pa_o   = {desc_i[DESC_W-1:SUPER_LSB], va_low_i[SUPER_LSB-1:0]};
            size_o = PG_16M;
          end else begin
            pa_o   = {desc_i[DESC_W-1:SECT_LSB], va_low_i[SECT_LSB-1:0]};
            size_o = PG_1M;
          end
        end
        default: kind_o = L1K_FAULT;
      endcase
    end
  end
endmodule

// File: rtl/iopt_l2_dec.sv
module iopt_l2_dec
  import iopt_pkg::*;
(
  input  logic [DESC_W-1:0]    desc_i,
  input  logic [LARGE_LSB-1:0] va_low_i,
  output logic                 ok_o,
  output logic [PA_W-1:0]      pa_o,
  output pg_size_e             size_o
);
  always_comb begin
    ok_o   = 1'b0;
    pa_o   = '0;
    size_o = PG_4K;
    if (desc_i != '0) begin
      if (desc_i[1]) begin
        ok_o   = 1'b1;
        pa_o   = {desc_i[DESC_W-1:SMALL_LSB], va_low_i[SMALL_LSB-1:0]};
        size_o = PG_4K;
      end else if (desc_i[0]) begin
        ok_o   = 1'b1;
        pa_o   = {desc_i[DESC_W-1:LARGE_LSB], va_low_i[LARGE_LSB-1:0]};
        size_o = PG_64K;
      end
    end
  end
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
  import iopt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BASE_W-1:0] tbl_base_i,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_addr_i,
  output logic              req_ready_o,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DESC_W-1:0] mem_rdata_i,
  output logic              res_valid_o,
  output logic [PA_W-1:0]   res_pa_o,
  output logic [1:0]        res_size_o,
  output logic              res_fault_o,
  output logic [VA_W-1:0]   res_fault_addr_o
);
  walk_st_e          state_q;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   maddr_q;
  logic [PA_W-1:0]   pa_q;
  pg_size_e          size_q;
  logic              fault_q;

  l1_kind_e          l1_kind;
  logic [PA_W-1:0]   l1_pa, l1_next;
  pg_size_e          l1_size;
  logic              l2_ok;
  logic [PA_W-1:0]   l2_pa;
  pg_size_e          l2_size;

  iopt_l1_dec i_l1_dec (
    .desc_i   (mem_rdata_i),
    .va_low_i (va_q[SUPER_LSB-1:0]),
    .kind_o   (l1_kind),
    .pa_o     (l1_pa),
    .size_o   (l1_size),
    .l2_addr_o(l1_next)
  );

  iopt_l2_dec i_l2_dec (
    .desc_i   (mem_rdata_i),
    .va_low_i (va_q[LARGE_LSB-1:0]),
    .ok_o     (l2_ok),
    .pa_o     (l2_pa),
    .size_o   (l2_size)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      maddr_q <= '0;
      pa_q    <= '0;
      size_q  <= PG_1M;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_addr_i;
          maddr_q <= {tbl_base_i, req_addr_i[VA_W-1:L1_IDX_LSB], 2'b00};
          state_q <= ST_L1_REQ;
        end
        ST_L1_REQ: state_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rvalid_i) begin
          unique case (l1_kind)
            L1K_TABLE: begin
              maddr_q <= l1_next;
              state_q <= ST_L2_REQ;
            end
            L1K_LEAF: begin
              pa_q    <= l1_pa;
              size_q  <= l1_size;
              fault_q <= 1'b0;
              state_q <= ST_DONE;
            end
            default: begin
              pa_q    <= '0;
              size_q  <= PG_1M;
              fault_q <= 1'b1;
              state_q <= ST_DONE;
            end
          endcase
        end
        ST_L2_REQ: state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rvalid_i) begin
          pa_q    <= l2_ok ? l2_pa : '0;
          size_q  <= l2_size;
          fault_q <= ~l2_ok;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o      = (state_q == ST_IDLE);
  assign mem_req_o        = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_addr_o       = maddr_q;
  assign res_valid_o      = (state_q == ST_DONE);
  assign res_pa_o         = pa_q;
  assign res_size_o       = size_q;
  assign res_fault_o      = fault_q;
  assign res_fault_addr_o = fault_q ? va_q : '0;
endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [17:0] tbl_base_i,
  input logic        req_valid_i,
  input logic [31:0] req_addr_i,
  input logic        req_ready_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic [31:0] mem_rdata_i,
  input logic        res_valid_o,
  input logic [31:0] res_pa_o,
  input logic [1:0]  res_size_o,
  input logic        res_fault_o,
  input logic [31:0] res_fault_addr_o
);
  logic        pend_q;
  logic [31:0] acc_va_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      acc_va_q <= '0;
    end else begin
      if (mem_req_o) pend_q <= 1'b1;
      else if (mem_rvalid_i) pend_q <= 1'b0;
      if (req_valid_i && req_ready_o) acc_va_q <= req_addr_i;
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R2
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !pend_q); // R2
  AST_L1_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=>
      (mem_req_o && mem_addr_o == {$past(tbl_base_i), $past(req_addr_i[31:20]), 2'b00})); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_o && !res_valid_o)); // R10
  AST_RES_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> (!res_valid_o && req_ready_o)); // R11
  AST_FAULT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_fault_o) |-> (res_fault_addr_o == acc_va_q && res_pa_o == '0)); // R8

  logic unused_ok;
  assign unused_ok = ^{mem_rdata_i, res_size_o};
endmodule

bind iopt_walker iopt_walker_chk i_chk (.*);

// File: tb/test_iopt_walker.sv
`timescale 1ns/1ps
module test_iopt_walker;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] tbl_base = 18'h00040;  // table at 0x0010_0000
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready_o, mem_req_o, mem_rvalid = 1'b0;
  logic [31:0] mem_addr_o, mem_rdata = '0;
  logic        res_valid_o, res_fault_o;
  logic [31:0] res_pa_o, res_fault_addr_o;
  logic [1:0]  res_size_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  iopt_walker i_iopt_walker (
    .clk_i(clk), .rst_ni(rst_ni), .tbl_base_i(tbl_base),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .res_valid_o(res_valid_o), .res_pa_o(res_pa_o), .res_size_o(res_size_o),
    .res_fault_o(res_fault_o), .res_fault_addr_o(res_fault_addr_o)
  );

  // sparse memory: {address, word}; anything else reads as zero
  localparam logic [63:0] MEM [8] = '{
    {32'h0010_048C, 32'h8760_0002},
    {32'h0010_0A84, 32'h95F4_0002},
    {32'h0010_1000, 32'h0020_0401},
    {32'h0020_0414, 32'h3333_3002},
    {32'h0020_04DC, 32'h7777_C001},
    {32'h0020_0404, 32'h4444_5003},
    {32'h0010_1400, 32'h1234_0003},
    {32'h0010_1800, 32'h0000_1000}
  };

  // {addr, exp_pa, exp_size, exp_fault, exp_reads}
  localparam logic [68:0] VEC [9] = '{
    {32'h1234_5678, 32'h8764_5678, 2'b00, 1'b0, 2'd1},
    {32'h2A12_3456, 32'h9512_3456, 2'b11, 1'b0, 2'd1},
    {32'h4000_5ABC, 32'h3333_3ABC, 2'b10, 1'b0, 2'd2},
    {32'h4003_7DEF, 32'h7777_7DEF, 2'b01, 1'b0, 2'd2},
    {32'h4000_1123, 32'h4444_5123, 2'b10, 1'b0, 2'd2},
    {32'h0BAD_0000, 32'h0000_0000, 2'b00, 1'b1, 2'd1},
    {32'h4009_9000, 32'h0000_0000, 2'b00, 1'b1, 2'd2},
    {32'h5000_0000, 32'h0000_0000, 2'b00, 1'b1, 2'd1},
    {32'h6000_0000, 32'h0000_0000, 2'b00, 1'b1, 2'd1}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R7";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] mem_lookup(logic [31:0] a);
    for (int m = 0; m < 8; m++)
      if (MEM[m][63:32] == a) return MEM[m][31:0];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] da, input bit poke,
                      output logic [31:0] pa, output logic [1:0] sz, output bit flt,
                      output logic [31:0] fa, output int nrd,
                      output logic [31:0] a1, output logic [31:0] a2, output bit got);
    logic [31:0] ra;
    @(negedge clk);
    req_valid = 1'b1; req_addr = da;
    @(negedge clk);
    req_valid = 1'b0;
    nrd = 0; got = 0; a1 = '0; a2 = '0; pa = '0; sz = '0; flt = 0; fa = '0;
    for (int k = 0; k < 100; k++) begin
      if (res_valid_o) begin
        pa = res_pa_o; sz = res_size_o; flt = res_fault_o; fa = res_fault_addr_o;
        got = 1;
        break;
      end
      if (mem_req_o) begin
        ra = mem_addr_o;
        if (nrd == 0) a1 = ra; else a2 = ra;
        nrd++;
        @(negedge clk);
        if (poke) begin
          chk(req_ready_o == 1'b0, "R10 ready low while busy", {31'd0, req_ready_o}, 32'd0);
          req_valid = 1'b1; req_addr = 32'h4000_5ABC;
        end
        @(negedge clk);
        req_valid = 1'b0;
        mem_rvalid = 1'b1; mem_rdata = mem_lookup(ra);
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = '0;
      end else begin
        @(negedge clk);
      end
    end
    if (got) begin
      @(negedge clk);
      chk(!res_valid_o && req_ready_o, "R11 single result pulse",
          {30'd0, res_valid_o, req_ready_o}, 32'd1);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa, fa, a1, a2, da;
    logic [1:0]  sz;
    bit          flt, got;
    int          nrd;

    repeat (3) @(negedge clk);
    chk(req_ready_o && !mem_req_o && !res_valid_o, "R1 in reset",
        {29'd0, req_ready_o, mem_req_o, res_valid_o}, 32'd4);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o && !mem_req_o && !res_valid_o, "R1 after reset",
        {29'd0, req_ready_o, mem_req_o, res_valid_o}, 32'd4);

    for (int i = 0; i < 9; i++) begin
      da = VEC[i][68:37];
      walk(da, 1'b0, pa, sz, flt, fa, nrd, a1, a2, got);
      chk(got, {tag_of(i), " result seen"}, {31'd0, got}, 32'd1);
      chk(pa == VEC[i][36:5], {tag_of(i), " pa"}, pa, VEC[i][36:5]);
      chk(flt == VEC[i][2], {tag_of(i), " fault"}, {31'd0, flt}, {31'd0, VEC[i][2]});
      if (!VEC[i][2])
        chk(sz == VEC[i][4:3], {tag_of(i), " size"}, {30'd0, sz}, {30'd0, VEC[i][4:3]});
      chk(fa == (VEC[i][2] ? da : 32'h0), "R8 fault addr", fa, VEC[i][2] ? da : 32'h0);
      chk(nrd == int'(VEC[i][1:0]), {tag_of(i), " read count"}, nrd, {30'd0, VEC[i][1:0]});
      chk(a1 == {tbl_base, da[31:20], 2'b00}, "R2 L1 address", a1, {tbl_base, da[31:20], 2'b00});
      if (VEC[i][1:0] == 2'd2)
        chk(a2 == {mem_lookup(a1)[31:10], da[19:12], 2'b00}, "R5 L2 address",
            a2, {mem_lookup(a1)[31:10], da[19:12], 2'b00});
    end

    // request raised mid-walk must not disturb the walk
    walk(32'h1234_5678, 1'b1, pa, sz, flt, fa, nrd, a1, a2, got);
    chk(got && pa == 32'h8764_5678, "R10 pa unchanged", pa, 32'h8764_5678);
    chk(nrd == 1, "R10 no extra read", nrd, 32'd1);
    @(negedge clk);
    chk(req_ready_o && !mem_req_o, "R10 idle after poke", {30'd0, req_ready_o, mem_req_o}, 32'd2);

    // different base: L1 address follows the captured base
    tbl_base = 18'h00080;
    walk(32'h0BAD_0000, 1'b0, pa, sz, flt, fa, nrd, a1, a2, got);
    chk(a1 == 32'h0020_02E8, "R2 base change", a1, 32'h0020_02E8);
    chk(flt && fa == 32'h0BAD_0000, "R8 fault with new base", fa, 32'h0BAD_0000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule